// File: doc/BRIEF.md
# Event Timer with Polarity Control

A 24-bit up-counter tied to one timer pin that can serve as a plain I/O bit, as a source of external events, or as a driven timer output. A two-bit mode field picks the role. An enable bit starts and stops the timer. A load value and a compare value set the counting window. A single polarity bit changes three things, depending on the mode: which pin edge counts as an event, whether the I/O bit is read and written true or inverted, and the level the timer output starts from.

Enabling the timer clears the counter. The first event then loads the load value N, and each further event adds one. With compare value M, the compare flag therefore sets on event number M − N + 1. When the counter steps from all-ones to zero, the overflow flag sets. Both flags stay set until they are cleared. Each interrupt output is its flag gated by its own enable bit. The register fields arrive as plain inputs; register decoding sits outside this block.

Top module: `evtimer_top`

## Requirements
- R1: During reset and after it, the counter, both flags, both interrupts and the pin output enable are 0.
- R2: A clock edge with enable set, when it was clear at the previous edge, clears the counter. The first event after that loads the load value. Each later event adds one.
- R3: The compare flag sets on the event whose new counter value equals the compare value. From enable, that is event number M − N + 1.
- R4: An event taken while the counter holds 0xFFFFFF wraps it to 0 and sets the overflow flag.
- R5: Each interrupt output equals its flag ANDed with its interrupt enable input.
- R6: Flags are sticky. A flag clears on a write-one strobe or while enable is low. A set in the same cycle as a clear strobe wins.
- R7: Mode encoding is as follows. 0 is general I/O and never counts. 1 counts pin edges. 2 counts clocks and drives the pin. 3 counts clocks and leaves the pin undriven.
- R8: In mode 1 the pin passes through a two-flop synchronizer. The count changes on the third clock edge after the pin changes. Rising edges count when polarity is 0, and falling edges count when polarity is 1.
- R9: The read bit is the synchronized pin level XOR the polarity bit.
- R10: In mode 0 with direction 1, the pin is driven with the write bit XOR the polarity bit.
- R11: In mode 2 while enabled, the pin is driven. Its level is the initial level XOR polarity, and it toggles on every compare match.
- R12: In mode 1, in mode 3, in mode 0 with direction 0, and in mode 2 while disabled, the output enable is 0.
- R13: While enable is low, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode select (0 I/O, 1 pin events, 2 pulse output, 3 clock count) |
| enable_i | input | 1 | Timer enable |
| inv_i | input | 1 | Polarity bit |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| dir_i | input | 1 | I/O direction in mode 0 (1 = drive) |
| wr_i | input | 1 | I/O write bit |
| init_lvl_i | input | 1 | Initial output level for mode 2 |
| load_i | input | 24 | Load value N |
| cmp_i | input | 24 | Compare value M |
| cmp_clr_i | input | 1 | Write-one clear strobe for compare flag |
| ovf_clr_i | input | 1 | Write-one clear strobe for overflow flag |
| pin_i | input | 1 | Pin input level |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| gpio_rd_o | output | 1 | I/O read bit |
| count_o | output | 24 | Counter value |
| cmp_flag_o | output | 1 | Compare flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_irq_o | output | 1 | Compare interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
Compare match and overflow wrap can fall on the same event. The bench provokes this by loading 0xFFFFFE with compare value 0. It expects both flags and both interrupts to rise together on the third clock event, with the counter at zero. A related collision joins a flag set with its own clear strobe. The bench raises the compare clear during the cycle of the matching event and expects the flag to stay set. The flag should then drop only on the following strobed cycle.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
  typedef enum logic [1:0] {
    MODE_GPIO      = 2'd0,
    MODE_PIN_EVT   = 2'd1,
    MODE_PULSE_OUT = 2'd2,
    MODE_CLK_CNT   = 2'd3
  } tmr_mode_e;

  localparam int FLAG_CMP = 0;
  localparam int FLAG_OVF = 1;
  localparam int N_FLAGS  = 2;

  // pick the counted edge from the polarity bit
  function automatic logic pick_edge(input logic rise, input logic fall, input logic inv);
    return inv ? fall : rise;
  endfunction

  // clock modes count every cycle, pin mode counts edges, gpio never counts
  function automatic logic mode_event(input tmr_mode_e mode, input logic pin_edge);
    case (mode)
      MODE_PIN_EVT:                return pin_edge;
      MODE_PULSE_OUT, MODE_CLK_CNT: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         run_i,
  input  logic         evt_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] count_o,
  output logic         match_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic [W-1:0] count_q;
  logic [W-1:0] nxt;
  logic         primed_q;
  logic         take;

  // first event after start loads, later ones increment
  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic primed,
                                        input logic [W-1:0] ld);
    return primed ? cur + ONE : ld;
  endfunction

  assign take    = run_i & evt_i;
  assign nxt     = step(count_q, primed_q, load_i);
  assign match_o = take & (nxt == cmp_i);
  assign wrap_o  = take & primed_q & (count_q == TOPV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      primed_q <= 1'b0;
    end else if (start_i) begin
      count_q  <= '0;
      primed_q <= 1'b0;
    end else if (take) begin
      count_q  <= nxt;
      primed_q <= 1'b1;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_sticky.sv
module tmr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic keep_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (!keep_i) flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_pin_mux.sv
module tmr_pin_mux
  import evtimer_pkg::*;
(
  input  tmr_mode_e mode_i,
  input  logic      enable_i,
  input  logic      dir_i,
  input  logic      wr_i,
  input  logic      inv_i,
  input  logic      out_lvl_i,
  input  logic      sync_lvl_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      gpio_rd_o
);
  always_comb begin
    pin_o    = 1'b0;
    pin_oe_o = 1'b0;
    case (mode_i)
      MODE_GPIO: begin
        pin_o    = wr_i ^ inv_i;
        pin_oe_o = dir_i;
      end
      MODE_PULSE_OUT: begin
        pin_o    = out_lvl_i ^ inv_i;
        pin_oe_o = enable_i;
      end
      default: begin
        pin_o    = 1'b0;
        pin_oe_o = 1'b0;
      end
    endcase
  end

  assign gpio_rd_o = sync_lvl_i ^ inv_i;
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             enable_i,
  input  logic             inv_i,
  input  logic             cmp_ie_i,
  input  logic             ovf_ie_i,
  input  logic             dir_i,
  input  logic             wr_i,
  input  logic             init_lvl_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             cmp_clr_i,
  input  logic             ovf_clr_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             gpio_rd_o,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o,
  output logic             cmp_irq_o,
  output logic             ovf_irq_o
);
  tmr_mode_e mode;
  logic      en_q;
  logic      start_evt;
  logic      run;
  logic      sync_lvl, sync_rise, sync_fall;
  logic      pin_edge;
  logic      evt;
  logic      match_evt;
  logic      wrap_evt;
  logic      out_q;
  logic [N_FLAGS-1:0] set_v, clr_v, flag_v, ie_v;

  assign mode      = tmr_mode_e'(mode_i);
  assign start_evt = enable_i & ~en_q;
  assign run       = enable_i & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (start_evt)      out_q <= init_lvl_i;
      else if (match_evt) out_q <= ~out_q;
    end
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .lvl_o (sync_lvl),
    .rise_o(sync_rise),
    .fall_o(sync_fall)
  );

  assign pin_edge = pick_edge(sync_rise, sync_fall, inv_i);
  assign evt      = mode_event(mode, pin_edge);

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_evt),
    .run_i  (run),
    .evt_i  (evt),
    .load_i (load_i),
    .cmp_i  (cmp_i),
    .count_o(count_o),
    .match_o(match_evt),
    .wrap_o (wrap_evt)
  );

  assign set_v[FLAG_CMP] = match_evt;
  assign set_v[FLAG_OVF] = wrap_evt;
  assign clr_v[FLAG_CMP] = cmp_clr_i;
  assign clr_v[FLAG_OVF] = ovf_clr_i;
  assign ie_v[FLAG_CMP]  = cmp_ie_i;
  assign ie_v[FLAG_OVF]  = ovf_ie_i;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    tmr_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .keep_i(enable_i),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .flag_o(flag_v[g])
    );
  end

  assign cmp_flag_o = flag_v[FLAG_CMP];
  assign ovf_flag_o = flag_v[FLAG_OVF];
  assign cmp_irq_o  = flag_v[FLAG_CMP] & ie_v[FLAG_CMP];
  assign ovf_irq_o  = flag_v[FLAG_OVF] & ie_v[FLAG_OVF];

  tmr_pin_mux u_mux (
    .mode_i    (mode),
    .enable_i  (enable_i),
    .dir_i     (dir_i),
    .wr_i      (wr_i),
    .inv_i     (inv_i),
    .out_lvl_i (out_q),
    .sync_lvl_i(sync_lvl),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .gpio_rd_o (gpio_rd_o)
  );
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             enable_i,
  input logic             dir_i,
  input logic             wr_i,
  input logic             inv_i,
  input logic             cmp_clr_i,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic [CNT_W-1:0] count_o,
  input logic             cmp_flag_o,
  input logic             ovf_flag_o,
  input logic             en_q,
  input logic             match_evt,
  input logic             wrap_evt
);
  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag_o);

  // R3
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag_o);

  // R6
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!cmp_flag_o && !ovf_flag_o));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag_o && enable_i && !cmp_clr_i) |=> cmp_flag_o);

  // R2
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !en_q) |=> (count_o == '0));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> $stable(count_o));

  // R12
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i != 2'd0) && (!enable_i || mode_i != 2'd2)) |-> !pin_oe_o);

  // R10
  gpio_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd0) && dir_i) |-> (pin_oe_o && (pin_o == (wr_i ^ inv_i))));
endmodule

bind evtimer_top evtimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .enable_i  (enable_i),
  .dir_i     (dir_i),
  .wr_i      (wr_i),
  .inv_i     (inv_i),
  .cmp_clr_i (cmp_clr_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .count_o   (count_o),
  .cmp_flag_o(cmp_flag_o),
  .ovf_flag_o(ovf_flag_o),
  .en_q      (en_q),
  .match_evt (match_evt),
  .wrap_evt  (wrap_evt)
);

// File: tb/evtimer_top_tb_top.sv
module evtimer_top_tb_top;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic enable_i = 1'b0, inv_i = 1'b0, cmp_ie_i = 1'b0, ovf_ie_i = 1'b0;
  logic dir_i = 1'b0, wr_i = 1'b0, init_lvl_i = 1'b0;
  logic [W-1:0] load_i = '0, cmp_i = '0;
  logic cmp_clr_i = 1'b0, ovf_clr_i = 1'b0, pin_i = 1'b0;
  logic pin_o, pin_oe_o, gpio_rd_o, cmp_flag_o, ovf_flag_o, cmp_irq_o, ovf_irq_o;
  logic [W-1:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evtimer_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enable_i(enable_i), .inv_i(inv_i),
    .cmp_ie_i(cmp_ie_i), .ovf_ie_i(ovf_ie_i), .dir_i(dir_i), .wr_i(wr_i),
    .init_lvl_i(init_lvl_i), .load_i(load_i), .cmp_i(cmp_i), .cmp_clr_i(cmp_clr_i),
    .ovf_clr_i(ovf_clr_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .gpio_rd_o(gpio_rd_o), .count_o(count_o), .cmp_flag_o(cmp_flag_o),
    .ovf_flag_o(ovf_flag_o), .cmp_irq_o(cmp_irq_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counter value after k events from enable
  function automatic logic [W-1:0] model_count(input logic [W-1:0] n, input int k);
    if (k == 0) return '0;
    return n + W'(k - 1);
  endfunction

  // compare hit within k events (no wrap in window)
  function automatic logic model_hit(input logic [W-1:0] n, input logic [W-1:0] m, input int k);
    if (m < n) return 1'b0;
    return (32'(m - n) + 1) <= k;
  endfunction

  // restart timer: drop enable one cycle, then raise it across one edge
  task automatic restart(input logic [1:0] md, input logic [W-1:0] n, input logic [W-1:0] m);
    enable_i = 1'b0;
    mode_i = md; load_i = n; cmp_i = m;
    tick(1);
    enable_i = 1'b1;
    tick(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    tick(3);
    // R1 reset state
    check("R1 count", 32'(count_o), 0);
    check("R1 flags", {cmp_flag_o, ovf_flag_o, cmp_irq_o, ovf_irq_o}, 0);
    check("R1 oe", 32'(pin_oe_o), 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after release", {count_o, cmp_flag_o, ovf_flag_o, pin_oe_o}, 0);

    // R9 gpio read
    mode_i = 2'd0; dir_i = 1'b0; pin_i = 1'b1; inv_i = 1'b0;
    tick(2);
    check("R9 read true", 32'(gpio_rd_o), 1);
    check("R12 gpio input oe", 32'(pin_oe_o), 0);
    inv_i = 1'b1; tick(1);
    check("R9 read inverted", 32'(gpio_rd_o), 0);
    pin_i = 1'b0; tick(2);
    check("R9 read inverted low", 32'(gpio_rd_o), 1);

    // R10 gpio write
    dir_i = 1'b1; wr_i = 1'b1; inv_i = 1'b0; tick(1);
    check("R10 drive true", {pin_oe_o, pin_o}, 2'b11);
    inv_i = 1'b1; tick(1);
    check("R10 drive inverted", {pin_oe_o, pin_o}, 2'b10);
    dir_i = 1'b0; inv_i = 1'b0;

    // R7 gpio mode never counts
    restart(2'd0, 24'd7, 24'd9);
    tick(5);
    check("R7 gpio no count", 32'(count_o), 0);

    // R11 pulse output
    init_lvl_i = 1'b1; inv_i = 1'b0;
    restart(2'd2, 24'd5, 24'd7);
    check("R11 initial level", {pin_oe_o, pin_o}, 2'b11);
    tick(2);
    check("R11 before match", 32'(pin_o), 1);
    tick(1);
    check("R11 toggled on match", 32'(pin_o), 0);
    check("R7 pulse mode counted", 32'(count_o), 7);
    inv_i = 1'b1; tick(1);
    check("R11 inverted output", 32'(pin_o), 1);
    enable_i = 1'b0; tick(1);
    check("R12 pulse disabled oe", 32'(pin_oe_o), 0);
    inv_i = 1'b0; init_lvl_i = 1'b0;

    // R4 + R3 overflow and compare on one event
    cmp_ie_i = 1'b1; ovf_ie_i = 1'b1;
    restart(2'd3, 24'hFFFFFE, 24'h000000);
    check("R12 clock mode oe", 32'(pin_oe_o), 0);
    tick(2);
    check("R4 at top", 32'(count_o), 32'hFFFFFF);
    check("R4 no early flag", {cmp_flag_o, ovf_flag_o}, 0);
    tick(1);
    check("R4 wrapped", 32'(count_o), 0);
    check("R4 ovf + R3 cmp same event", {cmp_flag_o, ovf_flag_o}, 2'b11);
    check("R5 both irqs", {cmp_irq_o, ovf_irq_o}, 2'b11);
    ovf_ie_i = 1'b0; tick(1);
    check("R5 ovf irq masked", {ovf_flag_o, ovf_irq_o}, 2'b10);
    ovf_clr_i = 1'b1; tick(1); ovf_clr_i = 1'b0;
    check("R6 ovf cleared by strobe", {cmp_flag_o, ovf_flag_o}, 2'b10);
    // R13 disable holds count, R6 flags drop
    enable_i = 1'b0; tick(1);
    begin
      logic [W-1:0] held;
      held = count_o;
      tick(5);
      check("R13 count held", 32'(count_o), 32'(held));
    end
    check("R6 flags drop when disabled", {cmp_flag_o, ovf_flag_o}, 0);

    // R6 set beats same-cycle clear
    restart(2'd3, 24'd10, 24'd12);
    tick(2);
    cmp_clr_i = 1'b1; tick(1);
    check("R6 set wins over clear", 32'(cmp_flag_o), 1);
    tick(1); cmp_clr_i = 1'b0;
    check("R6 later clear", 32'(cmp_flag_o), 0);

    // R8 pin events, R3 random windows
    for (int it = 0; it < 12; it++) begin
      logic [W-1:0] n, m, mc;
      logic pol, primed, fl;
      int pulses;
      pol = 1'($urandom);
      n = W'($urandom % 32'h00FFFF00);
      m = n + W'($urandom % 6);
      pulses = 1 + int'($urandom % 6);
      pin_i = 1'b0; inv_i = pol;
      tick(4);
      restart(2'd1, n, m);
      check("R12 event mode oe", 32'(pin_oe_o), 0);
      mc = '0; primed = 1'b0; fl = 1'b0;
      for (int p = 0; p < pulses; p++) begin
        for (int half = 0; half < 2; half++) begin
          pin_i = (half == 0);
          tick(1);
          check("R8 sync latency", 32'(count_o), 32'(mc));
          tick(2);
          if ((half == 0) != pol) begin
            mc = primed ? mc + 1'b1 : n;
            primed = 1'b1;
            if (mc == m) fl = 1'b1;
          end
          check("R8 edge counted", 32'(count_o), 32'(mc));
        end
      end
      check("R3 pin event compare", 32'(cmp_flag_o), 32'(fl));
    end
    inv_i = 1'b0;

    // R2 R3 R5 random clock windows
    for (int it = 0; it < 20; it++) begin
      logic [W-1:0] n, m;
      logic ie, hit;
      int k;
      n = W'($urandom % 32'h00FFFF00);
      m = n + W'($urandom % 20);
      k = 1 + int'($urandom % 25);
      ie = 1'($urandom);
      cmp_ie_i = ie;
      restart(2'd3, n, m);
      check("R2 cleared at enable", 32'(count_o), 0);
      tick(k);
      hit = model_hit(n, m, k);
      check("R2 count after events", 32'(count_o), 32'(model_count(n, k)));
      check("R3 compare after M-N+1", 32'(cmp_flag_o), 32'(hit));
      check("R5 compare irq gating", 32'(cmp_irq_o), 32'(hit & ie));
    end

    enable_i = 1'b0;
    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule